// File: doc/BRIEF.md
# Variable-length CAN receive FIFO

This block holds received CAN frames in a byte-wide ring buffer. Each frame is stored as a record whose length depends on the frame: an information byte, then two or four identifier bytes, then up to eight data bytes. A frame is presented in parallel on the write side for one cycle. The block latches it, checks that it is legal and that it fits, and then writes its record into the ring at one byte per cycle. While it does this it reports busy, and it ignores any new frame.

The read side is a window of byte offsets that starts at the oldest record. A CPU picks an offset and reads the addressed byte combinationally. To drop the head record, the CPU issues a release command. The block decodes the head record's information byte to find the record length, then moves the start pointer past it. A byte count and a message count track what the ring holds. A frame that does not fit is dropped and flagged as an overrun, which stays set until a clear command. Receive and overrun conditions appear both as status flags and as interrupt flags.

Top module: `canrx_rec_fifo`

## Requirements
- R1: A stored record starts with an information byte laid out as {extended, remote, 2'b00, dlc[3:0]}. An extended record then holds id[28:21], id[20:13], id[12:5] and {id[4:0], 3'b000}. A standard record then holds id[10:3] and {id[2:0], 5'b00000}. The data bytes follow, data byte i coming from frm_data[8i+7:8i].
- R2: The record length is 3 bytes for a standard frame or 5 for an extended one, plus the DLC only when the frame is not a remote frame. A remote frame stores no data bytes.
- R3: A frame with a DLC above 8 is discarded. Counts, flags and the buffer stay unchanged.
- R4: If the byte count plus the new record length would exceed the buffer size (64), the frame is dropped, ovr_flag and irq_ovr are set, and neither count changes.
- R5: A stored frame adds its length to byte_cnt, increments msg_cnt, and sets rx_avail and irq_rx.
- R6: When msg_cnt is nonzero, a release moves the window start past the head record. Its length is decoded from the head record's information byte as in R2. byte_cnt drops by that length and msg_cnt drops by one.
- R7: A release while msg_cnt is zero has no effect.
- R8: When a release brings msg_cnt to zero, rx_avail and irq_rx are cleared.
- R9: cmd_clr_ovr clears ovr_flag and irq_ovr. If an overrun is detected in the same cycle, the flags stay set.
- R10: busy and receiving rise in the cycle after a frame is accepted. They fall when the frame is stored, rejected or dropped. frm_valid has no effect while busy is high.
- R11: Window offset k reads the byte at (start + k) modulo 64, so records that wrap past the end of the ring read back contiguously.
- R12: A release that falls in the same cycle as the last byte of a store applies both effects. msg_cnt stays the same, byte_cnt changes by the stored length minus the released length, and rx_avail stays set.
- R13: After reset, both counts are zero, every flag is low and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame present on the write side; taken when busy is low |
| frm_ext | input | 1 | Extended (29-bit) identifier |
| frm_rtr | input | 1 | Remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_id | input | 29 | Identifier (standard frames use bits 10:0) |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Frame being evaluated or written |
| cmd_release | input | 1 | Release the head record |
| cmd_clr_ovr | input | 1 | Clear the overrun flags |
| win_ofs | input | 4 | Read-window byte offset from the head record |
| win_byte | output | 8 | Byte at the window offset |
| byte_cnt | output | 7 | Bytes held in the ring |
| msg_cnt | output | 7 | Records held in the ring |
| rx_avail | output | 1 | Receive-buffer status: at least one record held |
| ovr_flag | output | 1 | Overrun status |
| receiving | output | 1 | Receive-in-progress status |
| irq_rx | output | 1 | Receive interrupt flag |
| irq_ovr | output | 1 | Overrun interrupt flag |

## Verification
Two coincidences get directed tests. In the first, a release is timed to land on the clock edge that writes the last byte of a new record, so both counters take an increment and a decrement together. The bench checks that msg_cnt holds, that byte_cnt equals the old count minus the head length plus the new length, and that the window then shows the correct head. In the second, an overrun clear is driven into the cycle in which an oversized frame is evaluated, and the bench checks that the overrun flag stays set until a later clear on its own removes it.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  localparam int REC_MAX = 13;
  localparam int DLC_MAX = 8;

  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [3:0]  dlc;
    logic [28:0] id;
    logic [63:0] data;
  } canrx_frame_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_WRITE = 2'd2
  } canrx_state_e;

  // header bytes (info + identifier) for a format
  function automatic logic [4:0] hdr_len(input logic ext);
    return ext ? 5'd5 : 5'd3;
  endfunction

  // full record length; remote frames carry no payload
  function automatic logic [4:0] rec_len(input logic ext, input logic rtr,
                                         input logic [3:0] dlc);
    logic [4:0] n;
    n = hdr_len(ext);
    if (!rtr) n = n + {1'b0, dlc};
    return n;
  endfunction

  // length recovered from a stored information byte
  function automatic logic [4:0] info_len(input logic [7:0] info);
    return rec_len(info[7], info[6], info[3:0]);
  endfunction

endpackage

// File: rtl/canrx_serializer.sv
module canrx_serializer
  import canrx_pkg::*;
(
  input  canrx_frame_t                 frm,
  output logic [REC_MAX-1:0][7:0]      rec,
  output logic [4:0]                   len,
  output logic                         dlc_bad
);

  logic [31:0] id_left;

  // identifier left-aligned so the byte split is the same for both formats
  assign id_left = frm.ext ? {frm.id, 3'b000} : {frm.id[10:0], 21'd0};

  always_comb begin
    rec    = '0;
    rec[0] = {frm.ext, frm.rtr, 2'b00, frm.dlc};
    rec[1] = id_left[31:24];
    rec[2] = id_left[23:16];
    if (frm.ext) begin
      rec[3] = id_left[15:8];
      rec[4] = id_left[7:0];
      for (int i = 0; i < DLC_MAX; i++) begin
        if (!frm.rtr && (4'(i) < frm.dlc)) rec[5+i] = frm.data[8*i +: 8];
      end
    end else begin
      for (int i = 0; i < DLC_MAX; i++) begin
        if (!frm.rtr && (4'(i) < frm.dlc)) rec[3+i] = frm.data[8*i +: 8];
      end
    end
  end

  assign len     = rec_len(frm.ext, frm.rtr, frm.dlc);
  assign dlc_bad = frm.dlc > 4'(DLC_MAX);

endmodule

// File: rtl/canrx_byte_store.sv
module canrx_byte_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];

endmodule

// File: rtl/canrx_release_dec.sv
module canrx_release_dec
  import canrx_pkg::*;
(
  input  logic [7:0] head_info,
  input  logic       cmd,
  input  logic       have_msg,
  output logic       fire,
  output logic [4:0] len
);

  assign fire = cmd && have_msg;
  assign len  = info_len(head_info);

endmodule

// File: rtl/canrx_rec_fifo.sv
module canrx_rec_fifo
  import canrx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frm_valid,
  input  logic                       frm_ext,
  input  logic                       frm_rtr,
  input  logic [3:0]                 frm_dlc,
  input  logic [28:0]                frm_id,
  input  logic [63:0]                frm_data,
  output logic                       busy,
  input  logic                       cmd_release,
  input  logic                       cmd_clr_ovr,
  input  logic [3:0]                 win_ofs,
  output logic [7:0]                 win_byte,
  output logic [$clog2(DEPTH+1)-1:0] byte_cnt,
  output logic [$clog2(DEPTH+1)-1:0] msg_cnt,
  output logic                       rx_avail,
  output logic                       ovr_flag,
  output logic                       receiving,
  output logic                       irq_rx,
  output logic                       irq_ovr
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  function automatic logic [AW-1:0] ring_add(input logic [AW-1:0] base,
                                             input logic [4:0] step);
    int s;
    s = int'(base) + int'(step);
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  canrx_state_e              state_q;
  canrx_frame_t              frm_q;
  logic [AW-1:0]             wr_ptr_q, start_q;
  logic [3:0]                wr_idx_q;
  logic [CW-1:0]             byte_cnt_q, msg_cnt_q, byte_cnt_d, msg_cnt_d;
  logic                      rx_avail_q, irq_rx_q, ovr_q, irq_ovr_q, recv_q;

  logic [REC_MAX-1:0][7:0]   rec_w;
  logic [4:0]                rec_len_w;
  logic                      dlc_bad_w;
  logic [7:0]                head_info;
  logic [4:0]                rel_len;
  logic                      rel_fire;
  logic [AW-1:0]             win_addr;

  // named internal events
  logic in_eval, in_write, room_short, eval_reject, eval_ovr, store_done;

  canrx_serializer u_ser (
    .frm     (frm_q),
    .rec     (rec_w),
    .len     (rec_len_w),
    .dlc_bad (dlc_bad_w)
  );

  assign win_addr = ring_add(start_q, {1'b0, win_ofs});

  canrx_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (in_write),
    .waddr   (wr_ptr_q),
    .wdata   (rec_w[wr_idx_q]),
    .ra_addr (win_addr),
    .ra_data (win_byte),
    .rb_addr (start_q),
    .rb_data (head_info)
  );

  canrx_release_dec u_rel (
    .head_info (head_info),
    .cmd       (cmd_release),
    .have_msg  (msg_cnt_q != '0),
    .fire      (rel_fire),
    .len       (rel_len)
  );

  assign in_eval     = (state_q == ST_EVAL);
  assign in_write    = (state_q == ST_WRITE);
  assign room_short  = (int'(byte_cnt_q) + int'(rec_len_w)) > DEPTH;
  assign eval_reject = in_eval && dlc_bad_w;
  assign eval_ovr    = in_eval && !dlc_bad_w && room_short;
  assign store_done  = in_write && ({1'b0, wr_idx_q} == (rec_len_w - 5'd1));

  always_comb begin
    byte_cnt_d = byte_cnt_q;
    msg_cnt_d  = msg_cnt_q;
    if (store_done) begin
      byte_cnt_d = byte_cnt_d + CW'(rec_len_w);
      msg_cnt_d  = msg_cnt_d + CW'(1);
    end
    if (rel_fire) begin
      byte_cnt_d = byte_cnt_d - CW'(rel_len);
      msg_cnt_d  = msg_cnt_d - CW'(1);
    end
  end

  // frame intake and serial write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      frm_q    <= '0;
      wr_ptr_q <= '0;
      wr_idx_q <= '0;
      recv_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (frm_valid) begin
            frm_q   <= '{ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc,
                         id: frm_id, data: frm_data};
            state_q <= ST_EVAL;
            recv_q  <= 1'b1;
          end
        end
        ST_EVAL: begin
          if (dlc_bad_w || room_short) begin
            state_q <= ST_IDLE;
            recv_q  <= 1'b0;
          end else begin
            state_q  <= ST_WRITE;
            wr_idx_q <= '0;
          end
        end
        ST_WRITE: begin
          wr_ptr_q <= ring_add(wr_ptr_q, 5'd1);
          wr_idx_q <= wr_idx_q + 4'd1;
          if (store_done) begin
            state_q <= ST_IDLE;
            recv_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read side, counters and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= '0;
      byte_cnt_q <= '0;
      msg_cnt_q  <= '0;
      rx_avail_q <= 1'b0;
      irq_rx_q   <= 1'b0;
      ovr_q      <= 1'b0;
      irq_ovr_q  <= 1'b0;
    end else begin
      byte_cnt_q <= byte_cnt_d;
      msg_cnt_q  <= msg_cnt_d;
      if (rel_fire) start_q <= ring_add(start_q, rel_len);
      if (store_done) begin
        rx_avail_q <= 1'b1;
        irq_rx_q   <= 1'b1;
      end else if (rel_fire && (msg_cnt_q == CW'(1))) begin
        rx_avail_q <= 1'b0;
        irq_rx_q   <= 1'b0;
      end
      if (eval_ovr) begin
        ovr_q     <= 1'b1;
        irq_ovr_q <= 1'b1;
      end else if (cmd_clr_ovr) begin
        ovr_q     <= 1'b0;
        irq_ovr_q <= 1'b0;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign receiving = recv_q;
  assign byte_cnt  = byte_cnt_q;
  assign msg_cnt   = msg_cnt_q;
  assign rx_avail  = rx_avail_q;
  assign irq_rx    = irq_rx_q;
  assign ovr_flag  = ovr_q;
  assign irq_ovr   = irq_ovr_q;

endmodule

// File: rtl/canrx_rec_fifo_chk.sv
module canrx_rec_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          receiving,
  input logic [CW-1:0] byte_cnt,
  input logic [CW-1:0] msg_cnt,
  input logic          rx_avail,
  input logic          irq_rx,
  input logic          ovr_flag,
  input logic          cmd_release,
  input logic          store_done,
  input logic          rel_fire,
  input logic [4:0]    rel_len,
  input logic          eval_reject,
  input logic          eval_ovr
);

  AST_BYTES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    int'(byte_cnt) <= DEPTH); // R4

  AST_EMPTY_MEANS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_cnt == '0) |-> (!rx_avail && !irq_rx && byte_cnt == '0)); // R8

  AST_BUSY_IS_RECEIVING: assert property (@(posedge clk) disable iff (!rst_n)
    busy == receiving); // R10

  AST_REJECT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    eval_reject |=> !busy); // R3

  AST_OVR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    eval_ovr |=> ovr_flag); // R9

  AST_STORE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done && !rel_fire) |=> (msg_cnt == CW'($past(msg_cnt) + CW'(1)) && rx_avail)); // R5

  AST_RELEASE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_fire && !store_done) |=> (byte_cnt == CW'($past(byte_cnt) - CW'($past(rel_len))))); // R6

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_release && msg_cnt == '0 && !store_done) |=> (msg_cnt == '0)); // R7

  AST_COINCIDE_NET: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done && rel_fire) |=> (msg_cnt == $past(msg_cnt) && rx_avail)); // R12

endmodule

bind canrx_rec_fifo canrx_rec_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .receiving   (receiving),
  .byte_cnt    (byte_cnt),
  .msg_cnt     (msg_cnt),
  .rx_avail    (rx_avail),
  .irq_rx      (irq_rx),
  .ovr_flag    (ovr_flag),
  .cmd_release (cmd_release),
  .store_done  (store_done),
  .rel_fire    (rel_fire),
  .rel_len     (rel_len),
  .eval_reject (eval_reject),
  .eval_ovr    (eval_ovr)
);

// File: tb/canrx_rec_fifo_tb.sv
`timescale 1ns/1ps
module canrx_rec_fifo_tb;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [3:0]  frm_dlc = '0;
  logic [28:0] frm_id = '0;
  logic [63:0] frm_data = '0;
  logic        busy, cmd_release = 1'b0, cmd_clr_ovr = 1'b0;
  logic [3:0]  win_ofs = '0;
  logic [7:0]  win_byte;
  logic [6:0]  byte_cnt, msg_cnt;
  logic        rx_avail, ovr_flag, receiving, irq_rx, irq_ovr;

  always #4 clk = ~clk;

  canrx_rec_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
    .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_id(frm_id), .frm_data(frm_data),
    .busy(busy), .cmd_release(cmd_release), .cmd_clr_ovr(cmd_clr_ovr),
    .win_ofs(win_ofs), .win_byte(win_byte), .byte_cnt(byte_cnt),
    .msg_cnt(msg_cnt), .rx_avail(rx_avail), .ovr_flag(ovr_flag),
    .receiving(receiving), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  logic [7:0] mdl [DEPTH];
  int m_start = 0, m_wr = 0, m_bytes = 0, m_msgs = 0;
  bit m_ovr = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // record built by appending bytes in order
  task automatic build(input bit ext, input bit rtr, input logic [3:0] dlc,
                       input logic [28:0] id, input logic [63:0] data,
                       output logic [7:0] b [13], output int n);
    logic [31:0] w;
    logic [15:0] s;
    n = 0;
    for (int k = 0; k < 13; k++) b[k] = 8'h00;
    b[n] = {ext, rtr, 2'b00, dlc}; n++;
    if (ext) begin
      w = {id, 3'b000};
      for (int k = 0; k < 4; k++) begin b[n] = w[31-8*k -: 8]; n++; end
    end else begin
      s = {id[10:0], 5'b00000};
      b[n] = s[15:8]; n++;
      b[n] = s[7:0];  n++;
    end
    if (!rtr && dlc <= 8) for (int k = 0; k < int'(dlc); k++) begin b[n] = data[8*k +: 8]; n++; end
  endtask

  task automatic mdl_release();
    logic [7:0] inf;
    int len;
    if (m_msgs > 0) begin
      inf = mdl[m_start];
      len = (inf[7] ? 5 : 3) + (inf[6] ? 0 : int'(inf[3:0]));
      m_start = (m_start + len) % DEPTH;
      m_bytes -= len;
      m_msgs--;
    end
  endtask

  task automatic send(input bit ext, input bit rtr, input logic [3:0] dlc,
                      input logic [28:0] id, input logic [63:0] data,
                      input int rel_at, input int clr_at, input bit poke);
    logic [7:0] b [13];
    int n;
    build(ext, rtr, dlc, id, data, b, n);
    @(negedge clk);
    frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc; frm_id = id; frm_data = data;
    frm_valid = 1'b1;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      frm_valid   = (poke && i == 3);
      cmd_release = (i == rel_at);
      cmd_clr_ovr = (i == clr_at);
      if (i == 1) begin
        check("R10 busy after accept", int'(busy), 1);
        check("R10 receiving after accept", int'(receiving), 1);
      end
      if (!busy && i > rel_at && i > clr_at && !(poke && i < 5)) break;
    end
    frm_valid = 1'b0; cmd_release = 1'b0; cmd_clr_ovr = 1'b0;
    check("R10 receiving cleared at end", int'(receiving), 0);
    if (dlc > 8) begin
    end else if (m_bytes + n > DEPTH) begin
      m_ovr = 1;
    end else begin
      for (int k = 0; k < n; k++) mdl[(m_wr + k) % DEPTH] = b[k];
      m_wr = (m_wr + n) % DEPTH;
      m_bytes += n;
      m_msgs++;
    end
    if (rel_at > 0) mdl_release();
  endtask

  task automatic release_cmd();
    @(negedge clk); cmd_release = 1'b1;
    @(negedge clk); cmd_release = 1'b0;
    mdl_release();
  endtask

  task automatic clear_ovr();
    @(negedge clk); cmd_clr_ovr = 1'b1;
    @(negedge clk); cmd_clr_ovr = 1'b0;
    m_ovr = 0;
  endtask

  task automatic chk_state(input string req);
    check({req, " byte_cnt"}, int'(byte_cnt), m_bytes);
    check({req, " msg_cnt"},  int'(msg_cnt),  m_msgs);
    check({req, " rx_avail"}, int'(rx_avail), int'(m_msgs != 0));
    check({req, " irq_rx"},   int'(irq_rx),   int'(m_msgs != 0));
    check({req, " ovr_flag"}, int'(ovr_flag), int'(m_ovr));
    check({req, " irq_ovr"},  int'(irq_ovr),  int'(m_ovr));
  endtask

  task automatic chk_window(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      win_ofs = 4'(k);
      #1;
      check(req, int'(win_byte), int'(mdl[(m_start + k) % DEPTH]));
    end
    win_ofs = '0;
  endtask

  task automatic peek(input int k, output int v);
    win_ofs = 4'(k); #1; v = int'(win_byte); win_ofs = '0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    for (int k = 0; k < DEPTH; k++) mdl[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R13 reset");
    check("R13 busy at reset", int'(busy), 0);
    check("R13 receiving at reset", int'(receiving), 0);
  endtask

  task automatic t_std_ext();
    int v;
    send(1'b0, 1'b0, 4'd4, 29'h5A3, 64'h44332211, 0, 0, 1'b0);
    chk_state("R5 standard store");
    peek(0, v); check("R1 std info byte", v, 8'h04);
    peek(1, v); check("R1 std id high", v, 8'hB4);
    peek(2, v); check("R1 std id low", v, 8'h60);
    peek(3, v); check("R1 std data0", v, 8'h11);
    chk_window("R1 standard record", 7);
    send(1'b1, 1'b0, 4'd8, 29'h1ABCDEF1, 64'h8877665544332211, 0, 0, 1'b0);
    chk_state("R5 extended store");
    release_cmd();
    chk_state("R6 release standard head");
    peek(0, v); check("R1 ext info byte", v, 8'h88);
    peek(1, v); check("R1 ext id byte1", v, 8'hD5);
    peek(4, v); check("R1 ext id byte4", v, 8'h88);
    peek(5, v); check("R1 ext data0", v, 8'h11);
    chk_window("R6 window at extended head", 13);
  endtask

  task automatic t_rtr_reject();
    send(1'b0, 1'b1, 4'd5, 29'h123, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1'b1);
    chk_state("R2 remote frame length 3, R10 stalled poke");
    send(1'b1, 1'b0, 4'd9, 29'h0, 64'h0, 0, 0, 1'b0);
    chk_state("R3 dlc 9 rejected");
  endtask

  task automatic t_drain();
    int v0, v1;
    release_cmd();
    chk_window("R2 remote head window", 3);
    release_cmd();
    chk_state("R8 drained");
    peek(0, v0);
    release_cmd();
    chk_state("R7 release when empty");
    peek(0, v1);
    check("R7 window unchanged", v1, v0);
  endtask

  task automatic t_overrun_wrap();
    for (int j = 0; j < 4; j++)
      send(1'b1, 1'b0, 4'd8, 29'(32'h10000 * (j + 1) + 7), 64'h0102030405060708 + 64'(j), 0, 0, 1'b0);
    chk_state("R5 four extended records");
    send(1'b1, 1'b0, 4'd8, 29'h1FFFFFFF, 64'hDEAD, 0, 0, 1'b0);
    chk_state("R4 overrun drop");
    clear_ovr();
    chk_state("R9 clear overrun");
    send(1'b0, 1'b0, 4'd5, 29'h7FF, 64'hAABBCCDDEE, 0, 0, 1'b0);
    chk_state("R4 fits at 60 bytes");
    for (int j = 0; j < 5; j++) begin
      chk_window("R11 wrapped window", 13);
      release_cmd();
      chk_state("R6 release in wrap");
    end
  endtask

  task automatic t_coincide();
    send(1'b0, 1'b0, 4'd2, 29'h055, 64'hA5C3, 0, 0, 1'b0);
    chk_state("R5 setup");
    send(1'b1, 1'b0, 4'd3, 29'h0ABCDEF, 64'h334455, 9, 0, 1'b0);
    chk_state("R12 store and release together");
    chk_window("R12 window after coincidence", 8);
  endtask

  task automatic t_clr_vs_ovr();
    for (int j = 0; j < 4; j++)
      send(1'b1, 1'b0, 4'd8, 29'(j + 3), 64'h1111 * 64'(j + 1), 0, 0, 1'b0);
    chk_state("R5 refill");
    send(1'b1, 1'b0, 4'd8, 29'h5, 64'h9, 0, 1, 1'b0);
    chk_state("R9 overrun wins over clear");
    clear_ovr();
    chk_state("R9 later clear");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    t_reset();
    t_std_ext();
    t_rtr_reject();
    t_drain();
    t_overrun_wrap();
    t_coincide();
    t_clr_vs_ovr();
    report();
  end

endmodule